// File: doc/BRIEF.md
# DDR2 Burst Column Order Generator

This block turns one burst request into the series of low column indices that a DDR2 device walks through during a read or write burst. The controller presents a full column address with a one-cycle start pulse, together with a length select (4 or 8 beats) and an ordering select (sequential or interleaved). Starting on the next clock, the block emits one column per cycle with a valid flag, and raises a last flag on the final beat.

The three lowest column bits follow the wrap rules of the selected ordering. All bits above them are copied from the start address and stay constant for the whole burst. The length and ordering are captured when the burst starts, so the controller may change those inputs freely afterwards. While a burst is in progress the block reports busy and ignores any further start pulse.

Top module: `ddr2_burst_order`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, valid, last and busy are all 0.
- R2: A start pulse seen on a rising edge while busy is 0 begins a burst. On the following cycle valid is 1, busy is 1 and col_out equals start_col (beat 0).
- R3: Column bits at position 3 and above on col_out equal those of the captured start_col on every beat of a burst.
- R4: Sequential, length 8 (len8=1, ilv=0), start s: beat i has bit 2 = s[2] for i<4 and the inverse of s[2] for i>=4, and bits 1:0 = (s[1:0]+i) mod 4. A start of 1 gives 1,2,3,0,5,6,7,4.
- R5: Sequential, length 4 (len8=0, ilv=0): bits 1:0 of beat i = (s[1:0]+i) mod 4, and bit 2 stays at s[2]. A start of 2 gives 2,3,0,1.
- R6: Interleaved (ilv=1): beat i equals s XOR i over bits 2:0 for length 8, and over bits 1:0 with bit 2 fixed for length 4. A start of 5 at length 8 gives 5,4,7,6,1,0,3,2. A start of 3 at length 4 gives 3,2,1,0.
- R7: valid stays 1 for exactly 4 or 8 consecutive cycles, one index per cycle. last is 1 only on the final beat, and valid is 0 on the cycle after it.
- R8: busy equals 1 on every beat of a burst. A start pulse that arrives while busy is 1, the final beat included, has no effect on the running burst and does not begin a new one.
- R9: len8 and ilv are sampled only with an accepted start. Changing them during a burst leaves that burst's order and length unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle burst request |
| start_col | input | COL_W | Starting column address |
| len8 | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| col_out | output | COL_W | Column for the current beat |
| valid | output | 1 | A beat is on col_out |
| last | output | 1 | Final beat of the burst |
| busy | output | 1 | A burst is in progress |

## Verification
On every cycle, the assertions check the framing of a burst: beat 0 repeats the start address, last occurs only while valid is high and is followed by an idle cycle, valid stays high until last, and the upper column bits and the captured modes do not move inside a burst. The order of the low three bits for each start value and mode can only be shown by the bench. It runs all eight starts in all four modes and compares each beat with an order worked out from the wrap rules. The bench also covers starts and mode changes injected mid-burst, which must leave no trace on the outputs.

// File: rtl/ddr2_burst_order.sv
module ddr2_burst_order #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             len8,
  input  logic             ilv,
  output logic [COL_W-1:0] col_out,
  output logic             valid,
  output logic             last,
  output logic             busy
);
  localparam int LOW_W = 3;

  logic             active;
  logic [LOW_W-1:0] beat;
  logic [COL_W-1:0] base;
  logic             len8_q;
  logic             ilv_q;
  logic             final_beat;
  logic [1:0]       low2;
  logic             bit2;

  assign final_beat = active && (beat == (len8_q ? 3'd7 : 3'd3));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
      base   <= '0;
      len8_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (start && !active) begin
      active <= 1'b1;
      beat   <= '0;
      base   <= start_col;
      len8_q <= len8;
      ilv_q  <= ilv;
    end else if (active) begin
      if (final_beat) active <= 1'b0;
      beat <= beat + 3'd1;
    end
  end

  assign low2    = ilv_q ? (base[1:0] ^ beat[1:0]) : (base[1:0] + beat[1:0]);
  assign bit2    = base[2] ^ beat[2];
  assign col_out = {base[COL_W-1:LOW_W], bit2, low2};
  assign valid   = active;
  assign last    = final_beat;
  assign busy    = active;

  a_r7_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);
  a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !valid);
  a_r7_no_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last) |=> valid);
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (valid && busy && col_out == $past(start_col)));
  a_r3_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last) |=> $stable(col_out[COL_W-1:LOW_W]));
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last) |=> ($stable(len8_q) && $stable(ilv_q)));
  a_r8_busy_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> busy);
endmodule

// File: tb/ddr2_burst_order_tb.sv
module ddr2_burst_order_tb_top;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             len8 = 1'b0;
  logic             ilv = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             valid, last, busy;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  ddr2_burst_order #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len8(len8), .ilv(ilv), .col_out(col_out), .valid(valid),
    .last(last), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_idx(input int s, input int i, input bit l8, input bit il);
    int hi, lo;
    if (il) begin
      if (l8) return s ^ i;
      return (s & 4) | ((s & 3) ^ (i & 3));
    end
    lo = ((s % 4) + i) % 4;
    hi = s & 4;
    if (l8 && i >= 4) hi = 4 - hi;
    return hi + lo;
  endfunction

  task automatic launch(input int col, input bit l8, input bit il);
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(col); len8 = l8; ilv = il;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_burst(input int col, input bit l8, input bit il, input string req,
                           input bit disturb);
    int n;
    n = l8 ? 8 : 4;
    launch(col, l8, il);
    for (int i = 0; i < n; i++) begin
      chk({req, " valid"}, int'(valid), 1);
      chk({req, " R8 busy"}, int'(busy), 1);
      chk({req, " low index"}, int'(col_out[2:0]), ref_idx(col & 7, i, l8, il));
      chk({req, " R3 upper"}, int'(col_out[COL_W-1:3]), col >> 3);
      chk({req, " R7 last"}, int'(last), (i == n - 1) ? 1 : 0);
      if (disturb && i >= 1 && i < n - 1) begin
        start = 1'b1; start_col = COL_W'(col ^ 10'h2A5); len8 = ~l8; ilv = ~il;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk({req, " R7 idle after last"}, int'(valid), 0);
    chk({req, " R8 no restart"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid", int'(valid), 0);
    chk("R1 last", int'(last), 0);
    chk("R1 busy", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", int'(valid), 0);
    chk("R1 busy after release", int'(busy), 0);
  endtask

  task automatic t_examples();
    int seq8_1 [8] = '{1, 2, 3, 0, 5, 6, 7, 4};
    int seq8_6 [8] = '{6, 7, 4, 5, 2, 3, 0, 1};
    int ilv8_5 [8] = '{5, 4, 7, 6, 1, 0, 3, 2};
    for (int i = 0; i < 8; i++) begin
      chk("R4 example start 1", ref_idx(1, i, 1'b1, 1'b0), seq8_1[i]);
      chk("R4 example start 6", ref_idx(6, i, 1'b1, 1'b0), seq8_6[i]);
      chk("R6 example start 5", ref_idx(5, i, 1'b1, 1'b1), ilv8_5[i]);
    end
    run_burst(10'h001, 1'b1, 1'b0, "R4 seq8 s1", 1'b0);
    run_burst(10'h006, 1'b1, 1'b0, "R4 seq8 s6", 1'b0);
    run_burst(10'h002, 1'b0, 1'b0, "R5 seq4 s2", 1'b0);
    run_burst(10'h005, 1'b1, 1'b1, "R6 ilv8 s5", 1'b0);
    run_burst(10'h003, 1'b0, 1'b1, "R6 ilv4 s3", 1'b0);
  endtask

  task automatic t_sweep();
    for (int s = 0; s < 8; s++) begin
      run_burst(s | 10'h3C8, 1'b1, 1'b0, "R4 R2 sweep", 1'b0);
      run_burst(s | 10'h150, 1'b0, 1'b0, "R5 R2 sweep", 1'b0);
      run_burst(s | 10'h0A8, 1'b1, 1'b1, "R6 R2 sweep ilv8", 1'b0);
      run_burst(s | 10'h210, 1'b0, 1'b1, "R6 R2 sweep ilv4", 1'b0);
    end
  endtask

  task automatic t_disturb();
    run_burst(10'h2F3, 1'b1, 1'b0, "R8 R9 disturb seq8", 1'b1);
    run_burst(10'h11E, 1'b0, 1'b1, "R8 R9 disturb ilv4", 1'b1);
    run_burst(10'h085, 1'b0, 1'b0, "R8 R9 disturb seq4", 1'b1);
  endtask

  initial begin
    t_reset();
    t_examples();
    t_sweep();
    t_disturb();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule